// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a single line. It oversamples the line with a tick that runs at sixteen times the bit rate, decides each bit by a majority of three samples near the bit centre, and delivers the received byte together with a ninth bit. It supports an 8-bit frame and a 9-bit frame. A frame with a missing stop bit raises a sticky framing-error flag.

In 9-bit mode with the multiprocessor filter enabled, the block gates the receive-done flag in hardware. It accepts a frame only when the ninth bit is 1 and the byte matches the station's own address. The own address is compared under a mask, and a broadcast pattern is also accepted. Frames that fail the filter leave the data outputs and the receive-done flag unchanged, so a station sleeps through traffic meant for other stations.

A single shared control bit reaches either the framing-error flag or the frame-mode bit. A view-select input decides which one.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, ri_o, fe_o, rx_data_o and rx_bit9_o are 0, and the frame-mode bit is 0 (8-bit frame). ctl_top_q_o reads 0 in both views.
- R2: A low line seen while idle starts a frame. If the start bit's vote is high, the frame is abandoned and the outputs do not change.
- R3: Each bit is taken as the majority of three line samples at oversampling ticks 7, 8 and 9 of its 16-tick bit cell. A single wrong sample does not change the bit.
- R4: In 8-bit mode (mode bit 0) a frame is a low start bit, 8 data bits LSB first, then a stop bit. rx_data_o gets the data, rx_bit9_o gets the sampled stop bit, and ri_o is set at the stop bit's centre.
- R5: In 9-bit mode (mode bit 1) a ninth bit follows the 8 data bits, and its value is delivered on rx_bit9_o.
- R6: ri_o is never cleared by hardware. Only a ri_clr_i pulse clears it. A later accepted frame updates the data while ri_o stays 1.
- R7: A stop bit sampled low sets fe_o. fe_o stays set through later good frames. It is cleared only by writing 0 to the shared bit while fe_view_i is 1.
- R8: With fe_view_i = 1, the shared bit reads and writes fe_o. With fe_view_i = 0, it reads and writes the frame-mode bit (1 = 9-bit frame). A write in one view leaves the other bit unchanged.
- R9: In 9-bit mode with mp_en_i = 1, a frame whose ninth bit is 0 is discarded: rx_data_o, rx_bit9_o and ri_o are unchanged.
- R10: In that filtered mode, a frame with ninth bit 1 is accepted when the byte equals own_addr_i at every position where addr_mask_i is 1.
- R11: In that filtered mode, a frame with ninth bit 1 is accepted when the byte has a 1 at every position where (own_addr_i | addr_mask_i) is 1.
- R12: In that filtered mode, a frame with ninth bit 1 that meets neither R10 nor R11 is discarded, with the outputs unchanged.
- R13: mp_en_i has no effect in 8-bit mode: every frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| mp_en_i | input | 1 | Multiprocessor address filter enable |
| own_addr_i | input | 8 | Station address |
| addr_mask_i | input | 8 | Address mask, 1 = compared bit |
| ctl_top_we_i | input | 1 | Write strobe for the shared control bit |
| ctl_top_d_i | input | 1 | Write data for the shared control bit |
| fe_view_i | input | 1 | 1: shared bit is the framing-error flag, 0: frame-mode bit |
| ri_clr_i | input | 1 | Clears the receive-done flag |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth bit (9-bit mode) or stop bit (8-bit mode) |
| ri_o | output | 1 | Receive-done flag |
| fe_o | output | 1 | Sticky framing-error flag |
| ctl_top_q_o | output | 1 | Read value of the shared control bit |

## Verification
On every cycle, the assertions check four properties. The receive-done flag never drops without a clear request. The framing-error flag never drops without a clearing write in the error view. The data output never changes unless the receive-done flag is set. In filtered 9-bit mode, every rising receive-done flag comes with a ninth bit of 1 and an address that meets the given or broadcast rule. Other behaviours are shown only by the bench's directed frames: bit order, the majority vote against a single-tick glitch, the rejection of a false start, the routing of the shared bit between views, and the effect of each address example.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              frame9_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              b9_o,
  output logic              stop_ok_o,
  output logic              fr9_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int MID   = OSR / 2;
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(MID);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] CELL_END = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        smp_q;
  logic [DATA_W:0]   shreg_q;
  logic              fr9_q;
  logic              stop_q;
  logic              done_q;
  logic              vote;
  logic [IDX_W-1:0]  last_idx;

  assign vote     = maj3(smp_q[0], smp_q[1], rxd_i);
  assign last_idx = fr9_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      shreg_q <= '0;
      fr9_q   <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (state_q == RX_IDLE) begin
          if (!rxd_i) begin
            state_q <= RX_START;
            cnt_q   <= CNT_W'(1);
            fr9_q   <= frame9_i;
          end
        end else begin
          cnt_q <= (cnt_q == CELL_END) ? '0 : cnt_q + CNT_W'(1);
          if (cnt_q == SMP_A) smp_q[0] <= rxd_i;
          if (cnt_q == SMP_B) smp_q[1] <= rxd_i;
          if (cnt_q == SMP_C) begin
            unique case (state_q)
              RX_START: if (vote) state_q <= RX_IDLE;
              RX_BITS:  shreg_q[idx_q] <= vote;
              RX_STOP: begin
                stop_q  <= vote;
                done_q  <= 1'b1;
                state_q <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt_q == CELL_END) begin
            if (state_q == RX_START) begin
              state_q <= RX_BITS;
              idx_q   <= '0;
            end else if (state_q == RX_BITS) begin
              if (idx_q == last_idx) state_q <= RX_STOP;
              else                   idx_q   <= idx_q + IDX_W'(1);
            end
          end
        end
      end
    end
  end

  assign done_o    = done_q;
  assign data_o    = shreg_q[DATA_W-1:0];
  assign b9_o      = fr9_q ? shreg_q[DATA_W] : stop_q;
  assign stop_ok_o = stop_q;
  assign fr9_o     = fr9_q;
endmodule

// File: rtl/uart_rx_addr_filter.sv
module uart_rx_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              b9_i,
  input  logic              fr9_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              accept_o
);
  logic [DATA_W-1:0] given_ok;
  logic [DATA_W-1:0] bcast_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign given_ok[i] = !mask_i[i] || (data_i[i] == addr_i[i]);
    assign bcast_ok[i] = !(addr_i[i] | mask_i[i]) || data_i[i];
  end

  assign accept_o = !(fr9_i && mp_en_i) || (b9_i && ((&given_ok) || (&bcast_ok)));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] own_addr_i,
  input  logic [DATA_W-1:0] addr_mask_i,
  input  logic              ctl_top_we_i,
  input  logic              ctl_top_d_i,
  input  logic              fe_view_i,
  input  logic              ri_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              ri_o,
  output logic              fe_o,
  output logic              ctl_top_q_o
);
  logic              rxd_s;
  logic              done;
  logic [DATA_W-1:0] f_data;
  logic              f_b9;
  logic              f_stop;
  logic              fr9_lat;
  logic              accept;

  logic              frame9_q;
  logic              fe_q;
  logic              ri_q;
  logic [DATA_W-1:0] data_q;
  logic              b9_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .rxd_i    (rxd_s),
    .frame9_i (frame9_q),
    .done_o   (done),
    .data_o   (f_data),
    .b9_o     (f_b9),
    .stop_ok_o(f_stop),
    .fr9_o    (fr9_lat)
  );

  uart_rx_addr_filter #(.DATA_W(DATA_W)) u_filt (
    .data_i  (f_data),
    .b9_i    (f_b9),
    .fr9_i   (fr9_lat),
    .mp_en_i (mp_en_i),
    .addr_i  (own_addr_i),
    .mask_i  (addr_mask_i),
    .accept_o(accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame9_q <= 1'b0;
      fe_q     <= 1'b0;
      ri_q     <= 1'b0;
      data_q   <= '0;
      b9_q     <= 1'b0;
    end else begin
      if (ctl_top_we_i) begin
        if (fe_view_i) fe_q     <= ctl_top_d_i;
        else           frame9_q <= ctl_top_d_i;
      end
      // hardware set wins over a same-cycle software write
      if (done && !f_stop) fe_q <= 1'b1;
      if (ri_clr_i) ri_q <= 1'b0;
      if (done && accept) begin
        ri_q   <= 1'b1;
        data_q <= f_data;
        b9_q   <= f_b9;
      end
    end
  end

  assign rx_data_o   = data_q;
  assign rx_bit9_o   = b9_q;
  assign ri_o        = ri_q;
  assign fe_o        = fe_q;
  assign ctl_top_q_o = fe_view_i ? fe_q : frame9_q;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ri_o,
  input logic              ri_clr_i,
  input logic              fe_o,
  input logic              ctl_top_we_i,
  input logic              ctl_top_d_i,
  input logic              fe_view_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_bit9_o,
  input logic              mp_en_i,
  input logic [DATA_W-1:0] own_addr_i,
  input logic [DATA_W-1:0] addr_mask_i,
  input logic              fr9_lat
);
  logic [DATA_W-1:0] addr_p, mask_p;
  logic              given_hit, bcast_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_p <= '0;
      mask_p <= '0;
    end else begin
      addr_p <= own_addr_i;
      mask_p <= addr_mask_i;
    end
  end

  assign given_hit = ((rx_data_o ^ addr_p) & mask_p) == '0;
  assign bcast_hit = (rx_data_o & (addr_p | mask_p)) == (addr_p | mask_p);

  a_r6_ri_no_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_o && !ri_clr_i |=> ri_o);

  a_r7_fe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_o && !(ctl_top_we_i && fe_view_i && !ctl_top_d_i) |=> fe_o);

  a_r4_data_with_ri: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_data_o != $past(rx_data_o)) |-> ri_o);

  a_r9_mp_bit9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri_o) && $past(mp_en_i) && $past(fr9_lat) |-> rx_bit9_o);

  a_r12_addr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri_o) && $past(mp_en_i) && $past(fr9_lat) |-> (given_hit || bcast_hit));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ri_o        (ri_o),
  .ri_clr_i    (ri_clr_i),
  .fe_o        (fe_o),
  .ctl_top_we_i(ctl_top_we_i),
  .ctl_top_d_i (ctl_top_d_i),
  .fe_view_i   (fe_view_i),
  .rx_data_o   (rx_data_o),
  .rx_bit9_o   (rx_bit9_o),
  .mp_en_i     (mp_en_i),
  .own_addr_i  (own_addr_i),
  .addr_mask_i (addr_mask_i),
  .fr9_lat     (fr9_lat)
);

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       mp_en = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic [7:0] addr_mask = 8'h00;
  logic       top_we = 1'b0;
  logic       top_d = 1'b0;
  logic       fe_view = 1'b0;
  logic       ri_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, ri, fe, top_q;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int div_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (div_cnt == TICK_DIV - 1) begin
      div_cnt <= 0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1;
      tick    <= 1'b0;
    end
  end

  uart_addr_rx u_uart_addr_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rxd_i       (rxd),
    .tick16_i    (tick),
    .mp_en_i     (mp_en),
    .own_addr_i  (own_addr),
    .addr_mask_i (addr_mask),
    .ctl_top_we_i(top_we),
    .ctl_top_d_i (top_d),
    .fe_view_i   (fe_view),
    .ri_clr_i    (ri_clr),
    .rx_data_o   (rx_data),
    .rx_bit9_o   (rx_bit9),
    .ri_o        (ri),
    .fe_o        (fe),
    .ctl_top_q_o (top_q)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    rxd = v;
    wait_ticks(8);
    if (glitch) rxd = ~v;
    wait_ticks(1);
    rxd = v;
    wait_ticks(7);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input bit use9,
                            input logic stop, input int glitch_idx);
    wait_ticks(1);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], glitch_idx == i);
    if (use9) drive_bit(b9, 1'b0);
    drive_bit(stop, 1'b0);
    rxd = 1'b1;
    wait_ticks(24);
  endtask

  task automatic pulse_clr();
    @(negedge clk); ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
  endtask

  task automatic write_top(input logic view, input logic d);
    @(negedge clk); fe_view = view; top_d = d; top_we = 1'b1;
    @(negedge clk); top_we = 1'b0;
  endtask

  task automatic read_top(input logic view, output logic q);
    @(negedge clk); fe_view = view;
    #1 q = top_q;
  endtask

  task automatic t_reset();
    logic q;
    chk("R1 ri", {8'h0, ri}, 9'h0);
    chk("R1 fe", {8'h0, fe}, 9'h0);
    chk("R1 data", {1'b0, rx_data}, 9'h0);
    chk("R1 bit9", {8'h0, rx_bit9}, 9'h0);
    read_top(1'b0, q); chk("R1 mode view", {8'h0, q}, 9'h0);
    read_top(1'b1, q); chk("R1 fe view", {8'h0, q}, 9'h0);
  endtask

  task automatic t_frame8();
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, -1);
    chk("R4 data", {1'b0, rx_data}, 9'h0A5);
    chk("R4 stop in bit9", {8'h0, rx_bit9}, 9'h1);
    chk("R4 ri set", {8'h0, ri}, 9'h1);
    chk("R4 no fe", {8'h0, fe}, 9'h0);
    pulse_clr();
    chk("R6 ri cleared", {8'h0, ri}, 9'h0);
  endtask

  task automatic t_ri_sticky();
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1, -1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1, -1);
    chk("R6 data overwritten", {1'b0, rx_data}, 9'h03C);
    wait_ticks(40);
    chk("R6 ri held", {8'h0, ri}, 9'h1);
    pulse_clr();
  endtask

  task automatic t_glitch();
    send_frame(8'h00, 1'b0, 1'b0, 1'b1, 3);
    chk("R3 glitch high ignored", {1'b0, rx_data}, 9'h000);
    pulse_clr();
    send_frame(8'hFF, 1'b0, 1'b0, 1'b1, 0);
    chk("R3 glitch low ignored", {1'b0, rx_data}, 9'h0FF);
    pulse_clr();
  endtask

  task automatic t_false_start();
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(200);
    chk("R2 no ri", {8'h0, ri}, 9'h0);
    chk("R2 data kept", {1'b0, rx_data}, 9'h0FF);
  endtask

  task automatic t_framing();
    logic q;
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, -1);
    chk("R7 fe set", {8'h0, fe}, 9'h1);
    pulse_clr();
    send_frame(8'h66, 1'b0, 1'b0, 1'b1, -1);
    chk("R7 fe sticky", {8'h0, fe}, 9'h1);
    pulse_clr();
    write_top(1'b0, 1'b1);
    read_top(1'b1, q); chk("R8 fe untouched by mode write", {8'h0, q}, 9'h1);
    read_top(1'b0, q); chk("R8 mode written", {8'h0, q}, 9'h1);
    write_top(1'b1, 1'b0);
    chk("R7 fe cleared by write", {8'h0, fe}, 9'h0);
    read_top(1'b0, q); chk("R8 mode untouched by fe write", {8'h0, q}, 9'h1);
  endtask

  task automatic t_frame9();
    send_frame(8'h96, 1'b0, 1'b1, 1'b1, -1);
    chk("R5 data", {1'b0, rx_data}, 9'h096);
    chk("R5 bit9 zero", {8'h0, rx_bit9}, 9'h0);
    pulse_clr();
    send_frame(8'h11, 1'b1, 1'b1, 1'b1, -1);
    chk("R5 bit9 one", {rx_bit9, rx_data}, 9'h111);
    pulse_clr();
  endtask

  task automatic t_mp_filter();
    mp_en = 1'b1; own_addr = 8'hC0; addr_mask = 8'hF9;
    send_frame(8'hC2, 1'b0, 1'b1, 1'b1, -1);
    chk("R9 data frame dropped ri", {8'h0, ri}, 9'h0);
    chk("R9 data frame dropped data", {rx_bit9, rx_data}, 9'h111);
    send_frame(8'hC2, 1'b1, 1'b1, 1'b1, -1);
    chk("R10 given match", {ri, rx_data}, 9'h1C2);
    pulse_clr();
    send_frame(8'hF9, 1'b1, 1'b1, 1'b1, -1);
    chk("R11 broadcast match", {ri, rx_data}, 9'h1F9);
    pulse_clr();
    send_frame(8'hC1, 1'b1, 1'b1, 1'b1, -1);
    chk("R12 mismatch dropped", {ri, rx_data}, 9'h0F9);
    own_addr = 8'hE0; addr_mask = 8'hFC;
    send_frame(8'hE3, 1'b1, 1'b1, 1'b1, -1);
    chk("R10 given match 2", {ri, rx_data}, 9'h1E3);
    pulse_clr();
    send_frame(8'hFD, 1'b1, 1'b1, 1'b1, -1);
    chk("R11 broadcast match 2", {ri, rx_data}, 9'h1FD);
    pulse_clr();
    send_frame(8'hE4, 1'b1, 1'b1, 1'b1, -1);
    chk("R12 mismatch dropped 2", {ri, rx_data}, 9'h0FD);
  endtask

  task automatic t_mp_8bit();
    write_top(1'b0, 1'b0);
    send_frame(8'h77, 1'b0, 1'b0, 1'b1, -1);
    chk("R13 accepted in 8-bit mode", {ri, rx_data}, 9'h177);
    pulse_clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame8();
    t_ri_sticky();
    t_glitch();
    t_false_start();
    t_framing();
    t_frame9();
    t_mp_filter();
    t_mp_8bit();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule